// File: doc/BRIEF.md
# Redundant Reference Clock Switchover

This block picks one of two single-ended reference clocks, A and B, and passes it to a downstream PLL reference divider. The choice is made in one of three ways. A configuration bit can make it. An external select pin can make it. In automatic mode the block prefers one reference and falls back to the other. Automatic mode is always revertive: it returns to the preferred input as soon as that input is healthy again. A non-revertive automatic mode is not offered.

Each input has a missing-edge monitor in the system clock domain. A reference is marked bad when no rising edge arrives within a programmable number of system clock cycles. It is marked good again after a programmable run of consecutive edges.

The change of clock is glitch-free and break-before-make. Each reference owns a gate enable, and that enable only changes on the falling edges of its own clock. The old clock is gated off on its own falling edge. The new clock is gated on after two of its own falling edges, and only once the old gate is fully drained. If a reference is no longer requested and its monitor calls it dead, its gate is cleared directly, so a stopped old clock cannot hold the switch forever. A bypass bit skips all of this: the output then follows a plain multiplexer and changes at once.

A controller in the system clock domain tracks the switch with four states:
- `ST_ON_A`: A is gated through.
- `ST_GO_B`: a change to B is in progress.
- `ST_ON_B`: B is gated through.
- `ST_GO_A`: a change to A is in progress.

Its transitions are:
- **start**: `ST_ON_A`→`ST_GO_B` or `ST_ON_B`→`ST_GO_A`, taken when the target differs from the active input.
- **land**: `ST_GO_B`→`ST_ON_B` or `ST_GO_A`→`ST_ON_A`. This is taken when the synchronised enables show the new gate on and the old gate off. With the bypass bit set, it is taken in the next cycle.
- **abort**: `ST_GO_B`→`ST_ON_A` or `ST_GO_A`→`ST_ON_B`, taken when the target returns to the origin before the switch lands.
- **hold**: any state to itself.

Top module: `refsw_switchover`

## Requirements
- R1: While reset is asserted, `ref_out` is 0, `sel_b_active` is 0 (meaning A) and both `ref_ok` bits are 0. After reset, A is selected and its clock appears at `ref_out`.
- R2: In manual mode (`cfg_auto`=0) with `cfg_pin_mode`=0, the input is set by `cfg_sel_b`: 0 selects A, 1 selects B. `sel_pin` has no effect in this mode.
- R3: In manual mode with `cfg_pin_mode`=1, the input is set by `sel_pin` after a two-flop synchroniser: 0 selects A, 1 selects B. `cfg_sel_b` has no effect in this mode.
- R4: In automatic mode with `cfg_pref_b`=0, A is used while `ref_ok[0]`=1 and B is used while `ref_ok[0]`=0. The block returns to A when A becomes good again. The manual select inputs are ignored.
- R5: In automatic mode with `cfg_pref_b`=1, the roles are swapped. B is used while `ref_ok[1]`=1 and A is used otherwise.
- R6: With deglitching on, a switch to a reference that is not toggling never completes. `ref_out` stays low and `sel_b_active` keeps its old value. The switch completes once the target starts toggling.
- R7: With `cfg_deglitch_off`=1, `ref_out` follows the requested reference directly. `sel_b_active` reaches the new value within two system clock cycles, even when the target is stopped.
- R8: With deglitching on, the two gate enables are never on together. `ref_out` never shows a high or low phase shorter than the shorter half period of the two references.
- R9: `ref_ok[i]` goes to 0 once no rising edge of that reference is seen for `cfg_miss_window` system clock cycles. It goes back to 1 after `cfg_valid_edges` consecutive edges, where a value of 0 counts as 1.
- R10: With deglitching on, `sel_b_active` changes only after the new reference's gate is on and the old gate is off. During the switch it keeps the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for monitors and controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a | input | 1 | Reference clock A |
| ref_b | input | 1 | Reference clock B |
| cfg_auto | input | 1 | 1 = automatic revertive mode |
| cfg_pref_b | input | 1 | Preferred reference in automatic mode (1 = B) |
| cfg_pin_mode | input | 1 | Manual source: 1 = `sel_pin`, 0 = `cfg_sel_b` |
| cfg_sel_b | input | 1 | Manual select bit (1 = B) |
| sel_pin | input | 1 | External select pin (1 = B), asynchronous |
| cfg_deglitch_off | input | 1 | 1 = bypass the glitch-free switching |
| cfg_miss_window | input | WIN_W | Cycles without a rising edge before a reference is marked bad |
| cfg_valid_edges | input | EDGE_W | Consecutive edges needed to mark a reference good |
| ref_out | output | 1 | Selected reference clock |
| sel_b_active | output | 1 | 1 when B is the reference gated through |
| ref_ok | output | 2 | Monitor result per reference (bit 0 = A, bit 1 = B) |

## Verification
The assertions assume the following about the inputs:
- A reference that stops is held at a clean low level, not left floating or chattering.
- The configuration inputs change in step with `sys_clk`.
- The bypass bit is never changed while a switch is pending.

Under these assumptions, the gate enables only move on edges that are far apart from the `sys_clk` sampling points. The stimulus keeps to these rules:
- It stops and restarts the reference clocks only in their low phase.
- It changes configuration on the falling edge of `sys_clk`.
- It sets or clears the bypass bit only after a switch has landed.
- It places the reference edges on a fractional-nanosecond offset, so no reference edge ever coincides with a system clock edge.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    localparam int unsigned NUM_REF = 2;

    typedef enum logic [1:0] {
        ST_ON_A = 2'd0,
        ST_GO_B = 2'd1,
        ST_ON_B = 2'd2,
        ST_GO_A = 2'd3
    } sw_state_e;

endpackage

// File: rtl/refsw_edge_mon.sv
module refsw_edge_mon #(
    parameter int unsigned WIN_W  = 16,
    parameter int unsigned EDGE_W = 4,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic [WIN_W-1:0]  miss_window,
    input  logic [EDGE_W-1:0] need_edges,
    output logic              ok
);

    localparam logic [EDGE_W-1:0] EDGE_ONE = EDGE_W'(1);
    localparam logic [WIN_W-1:0]  GAP_ONE  = WIN_W'(1);

    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              rise;
    logic [WIN_W-1:0]  gap_q;
    logic [EDGE_W-1:0] edges_q;
    logic [EDGE_W-1:0] need_eff;
    logic [EDGE_W:0]   edges_inc;
    logic              ok_q;

    // bring the reference into the system domain and find its rising edges
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], ref_clk};
            prev_q <= sync_q[SYNC_N-1];
        end
    end

    assign rise      = sync_q[SYNC_N-1] & ~prev_q;
    assign need_eff  = (need_edges == '0) ? EDGE_ONE : need_edges;
    assign edges_inc = {1'b0, edges_q} + {{EDGE_W{1'b0}}, 1'b1};

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            edges_q <= '0;
            ok_q    <= 1'b0;
        end else if (rise) begin
            gap_q <= '0;
            if (edges_inc <= {1'b0, need_eff}) begin
                edges_q <= edges_inc[EDGE_W-1:0];
            end
            if (edges_inc >= {1'b0, need_eff}) begin
                ok_q <= 1'b1;
            end
        end else begin
            if (gap_q != '1) begin
                gap_q <= gap_q + GAP_ONE;
            end
            if (gap_q >= miss_window) begin
                ok_q    <= 1'b0;
                edges_q <= '0;
            end
        end
    end

    assign ok = ok_q;

endmodule

// File: rtl/refsw_gate_cell.sv
module refsw_gate_cell #(
    parameter int unsigned GATE_N = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic kill,
    input  logic req,
    input  logic other_busy,
    output logic en,
    output logic busy
);

    logic              clr_n;
    logic [GATE_N-1:0] stg_q;

    // a dead, unrequested clock is cleared without waiting for its edges
    assign clr_n = rst_n & ~kill;

    always_ff @(negedge ref_clk or negedge clr_n) begin
        if (!clr_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[GATE_N-2:0], req & ~other_busy};
        end
    end

    assign en   = stg_q[GATE_N-1];
    assign busy = |stg_q;

endmodule

// File: rtl/refsw_ctrl_fsm.sv
module refsw_ctrl_fsm
    import refsw_pkg::*;
(
    input  logic       sys_clk,
    input  logic       rst_n,
    input  logic       target_b,
    input  logic       bypass,
    input  logic [1:0] en_seen,
    output logic       req_b,
    output logic       active_b
);

    sw_state_e state_q;
    sw_state_e state_d;
    logic      landed_b;
    logic      landed_a;

    assign landed_b = bypass | (en_seen[1] & ~en_seen[0]);
    assign landed_a = bypass | (en_seen[0] & ~en_seen[1]);

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ON_A;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ON_A: if (target_b)  state_d = ST_GO_B;
            ST_GO_B: begin
                if (!target_b)     state_d = ST_ON_A;
                else if (landed_b) state_d = ST_ON_B;
            end
            ST_ON_B: if (!target_b) state_d = ST_GO_A;
            ST_GO_A: begin
                if (target_b)      state_d = ST_ON_B;
                else if (landed_a) state_d = ST_ON_A;
            end
            default:               state_d = ST_ON_A;
        endcase
    end

    always_comb begin
        req_b    = 1'b0;
        active_b = 1'b0;
        unique case (state_q)
            ST_ON_A: begin req_b = 1'b0; active_b = 1'b0; end
            ST_GO_B: begin req_b = 1'b1; active_b = 1'b0; end
            ST_ON_B: begin req_b = 1'b1; active_b = 1'b1; end
            ST_GO_A: begin req_b = 1'b0; active_b = 1'b1; end
            default: begin req_b = 1'b0; active_b = 1'b0; end
        endcase
    end

endmodule

// File: rtl/refsw_switchover.sv
module refsw_switchover
    import refsw_pkg::*;
#(
    parameter int unsigned WIN_W  = 16,
    parameter int unsigned EDGE_W = 4,
    parameter int unsigned SYNC_N = 2,
    parameter int unsigned GATE_N = 2
) (
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic              ref_a,
    input  logic              ref_b,
    input  logic              cfg_auto,
    input  logic              cfg_pref_b,
    input  logic              cfg_pin_mode,
    input  logic              cfg_sel_b,
    input  logic              sel_pin,
    input  logic              cfg_deglitch_off,
    input  logic [WIN_W-1:0]  cfg_miss_window,
    input  logic [EDGE_W-1:0] cfg_valid_edges,
    output logic              ref_out,
    output logic              sel_b_active,
    output logic [1:0]        ref_ok
);

    logic [NUM_REF-1:0] ref_in;
    logic [NUM_REF-1:0] gate_req;
    logic [NUM_REF-1:0] gate_en;
    logic [NUM_REF-1:0] gate_busy;
    logic [NUM_REF-1:0] gate_kill;
    logic [NUM_REF-1:0] en_seen;
    logic [SYNC_N-1:0]  pin_sync_q;
    logic               pref_ok;
    logic               target_b;
    logic               req_b;

    assign ref_in = {ref_b, ref_a};

    // external select pin is asynchronous
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_sync_q <= '0;
        end else begin
            pin_sync_q <= {pin_sync_q[SYNC_N-2:0], sel_pin};
        end
    end

    // selection policy: manual bit, manual pin, or revertive automatic
    always_comb begin
        pref_ok = cfg_pref_b ? ref_ok[1] : ref_ok[0];
        if (cfg_auto) begin
            target_b = pref_ok ? cfg_pref_b : ~cfg_pref_b;
        end else if (cfg_pin_mode) begin
            target_b = pin_sync_q[SYNC_N-1];
        end else begin
            target_b = cfg_sel_b;
        end
    end

    assign gate_req = {req_b, ~req_b};

    for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
        logic              kill_q;
        logic [SYNC_N-1:0] es_q;

        refsw_edge_mon #(
            .WIN_W  (WIN_W),
            .EDGE_W (EDGE_W),
            .SYNC_N (SYNC_N)
        ) u_mon (
            .sys_clk     (sys_clk),
            .rst_n       (rst_n),
            .ref_clk     (ref_in[g]),
            .miss_window (cfg_miss_window),
            .need_edges  (cfg_valid_edges),
            .ok          (ref_ok[g])
        );

        always_ff @(posedge sys_clk or negedge rst_n) begin
            if (!rst_n) begin
                kill_q <= 1'b0;
                es_q   <= '0;
            end else begin
                kill_q <= ~gate_req[g] & ~ref_ok[g];
                es_q   <= {es_q[SYNC_N-2:0], gate_en[g]};
            end
        end

        assign gate_kill[g] = kill_q;
        assign en_seen[g]   = es_q[SYNC_N-1];

        refsw_gate_cell #(
            .GATE_N (GATE_N)
        ) u_gate (
            .ref_clk    (ref_in[g]),
            .rst_n      (rst_n),
            .kill       (gate_kill[g]),
            .req        (gate_req[g]),
            .other_busy (gate_busy[NUM_REF-1-g]),
            .en         (gate_en[g]),
            .busy       (gate_busy[g])
        );
    end

    refsw_ctrl_fsm u_fsm (
        .sys_clk  (sys_clk),
        .rst_n    (rst_n),
        .target_b (target_b),
        .bypass   (cfg_deglitch_off),
        .en_seen  (en_seen),
        .req_b    (req_b),
        .active_b (sel_b_active)
    );

    always_comb begin
        if (cfg_deglitch_off) begin
            ref_out = req_b ? ref_b : ref_a;
        end else begin
            ref_out = |(ref_in & gate_en);
        end
    end

endmodule

// File: rtl/refsw_switchover_chk.sv
module refsw_switchover_chk (
    input logic       sys_clk,
    input logic       rst_n,
    input logic       cfg_auto,
    input logic       cfg_pref_b,
    input logic       cfg_deglitch_off,
    input logic [1:0] ref_ok,
    input logic [1:0] gate_en,
    input logic       req_b,
    input logic       sel_b_active
);

    assert_break_before_make_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !(gate_en[0] && gate_en[1]));

    assert_flag_b_after_gate_R10: assert property (@(posedge sys_clk)
        disable iff (!rst_n || cfg_deglitch_off)
        $rose(sel_b_active) |-> gate_en[1] && !gate_en[0]);

    assert_flag_a_after_gate_R10: assert property (@(posedge sys_clk)
        disable iff (!rst_n || cfg_deglitch_off)
        $fell(sel_b_active) |-> gate_en[0] && !gate_en[1]);

    assert_auto_holds_pref_a_R4: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (cfg_auto && !cfg_pref_b && ref_ok[0]) |=> !req_b);

    assert_auto_backup_b_R4: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (cfg_auto && !cfg_pref_b && !ref_ok[0]) |=> req_b);

    assert_auto_holds_pref_b_R5: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (cfg_auto && cfg_pref_b && ref_ok[1]) |=> req_b);

endmodule

bind refsw_switchover refsw_switchover_chk u_chk (
    .sys_clk          (sys_clk),
    .rst_n            (rst_n),
    .cfg_auto         (cfg_auto),
    .cfg_pref_b       (cfg_pref_b),
    .cfg_deglitch_off (cfg_deglitch_off),
    .ref_ok           (ref_ok),
    .gate_en          (gate_en),
    .req_b            (req_b),
    .sel_b_active     (sel_b_active)
);

// File: tb/refsw_switchover_tb.sv
`timescale 1ns/100ps
module refsw_switchover_tb;

    localparam int WIN_W  = 16;
    localparam int EDGE_W = 4;
    localparam int PER_A  = 40;
    localparam int PER_B  = 64;

    logic sys_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic ref_a   = 1'b0;
    logic ref_b   = 1'b0;
    logic a_on    = 1'b1;
    logic b_on    = 1'b1;
    logic cfg_auto = 1'b0, cfg_pref_b = 1'b0, cfg_pin_mode = 1'b0;
    logic cfg_sel_b = 1'b0, sel_pin = 1'b0, cfg_deglitch_off = 1'b0;
    logic [WIN_W-1:0]  cfg_miss_window = 16'd32;
    logic [EDGE_W-1:0] cfg_valid_edges = 4'd4;
    logic       ref_out;
    logic       sel_b_active;
    logic [1:0] ref_ok;

    int  checks   = 0;
    int  failures = 0;
    int  runts    = 0;
    real last_t   = -1.0;

    always #2.5 sys_clk = ~sys_clk;

    // stopped references are parked low
    initial begin
        #0.3;
        forever begin #20; ref_a = a_on ? ~ref_a : 1'b0; end
    end
    initial begin
        #0.3;
        forever begin #32; ref_b = b_on ? ~ref_b : 1'b0; end
    end

    refsw_switchover #(.WIN_W(WIN_W), .EDGE_W(EDGE_W)) u_dut (
        .sys_clk          (sys_clk),
        .rst_n            (rst_n),
        .ref_a            (ref_a),
        .ref_b            (ref_b),
        .cfg_auto         (cfg_auto),
        .cfg_pref_b       (cfg_pref_b),
        .cfg_pin_mode     (cfg_pin_mode),
        .cfg_sel_b        (cfg_sel_b),
        .sel_pin          (sel_pin),
        .cfg_deglitch_off (cfg_deglitch_off),
        .cfg_miss_window  (cfg_miss_window),
        .cfg_valid_edges  (cfg_valid_edges),
        .ref_out          (ref_out),
        .sel_b_active     (sel_b_active),
        .ref_ok           (ref_ok)
    );

    // R8: phase width watch on the output while deglitching is active
    always @(ref_out) begin
        if (!rst_n || cfg_deglitch_off) begin
            last_t = -1.0;
        end else begin
            if (last_t >= 0.0 && ($realtime - last_t) < 19.0) runts++;
            last_t = $realtime;
        end
    end

    // fields: auto, pref_b, pin_mode, sel_b, pin, a_on, b_on, expected B
    localparam logic [7:0] VEC [0:10] = '{
        8'b0000_1110, 8'b0001_0111, 8'b0010_1111, 8'b0011_0110,
        8'b1001_0110, 8'b1001_0011, 8'b1001_0110, 8'b1100_0111,
        8'b1100_0100, 8'b1100_0111, 8'b1011_1110
    };

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic measure(output int rises, output int per);
        real t_first = 0.0;
        real t_last  = 0.0;
        logic prev = ref_out;
        rises = 0;
        for (int k = 0; k < 400; k++) begin
            #1;
            if (ref_out && !prev) begin
                if (rises == 0) t_first = $realtime;
                t_last = $realtime;
                rises++;
            end
            prev = ref_out;
        end
        per = (rises > 1) ? int'((t_last - t_first) / (rises - 1)) : 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int rises;
        int per;
        string rq;

        wait_cyc(6);
        check(ref_out == 1'b0, "R1", "ref_out in reset", int'(ref_out), 0);
        check(sel_b_active == 1'b0, "R1", "flag in reset", int'(sel_b_active), 0);
        check(ref_ok == 2'b00, "R1", "ref_ok in reset", int'(ref_ok), 0);
        rst_n = 1'b1;
        wait_cyc(300);
        check(sel_b_active == 1'b0, "R1", "flag after reset", int'(sel_b_active), 0);
        check(ref_ok == 2'b11, "R9", "both good after reset", int'(ref_ok), 3);
        measure(rises, per);
        check(per == PER_A, "R1", "period after reset", per, PER_A);

        for (int v = 0; v < 11; v++) begin
            @(negedge sys_clk);
            {cfg_auto, cfg_pref_b, cfg_pin_mode, cfg_sel_b, sel_pin, a_on, b_on} = VEC[v][7:1];
            rq = VEC[v][7] ? (VEC[v][6] ? "R5" : "R4") : (VEC[v][5] ? "R3" : "R2");
            wait_cyc(300);
            check(sel_b_active == VEC[v][0], rq, $sformatf("vector %0d flag", v),
                  int'(sel_b_active), int'(VEC[v][0]));
            measure(rises, per);
            check(per == (VEC[v][0] ? PER_B : PER_A), rq, $sformatf("vector %0d period", v),
                  per, VEC[v][0] ? PER_B : PER_A);
        end

        // back to manual register selection of A
        @(negedge sys_clk);
        cfg_auto = 1'b0; cfg_pin_mode = 1'b0; cfg_sel_b = 1'b0; sel_pin = 1'b0;
        wait_cyc(300);

        // R10: flag keeps the old value while the switch is in flight
        cfg_sel_b = 1'b1;
        wait_cyc(2);
        check(sel_b_active == 1'b0, "R10", "flag mid switch", int'(sel_b_active), 0);
        wait_cyc(300);
        check(sel_b_active == 1'b1, "R10", "flag after landing", int'(sel_b_active), 1);
        measure(rises, per);
        check(per == PER_B, "R2", "manual B period", per, PER_B);
        @(negedge sys_clk);
        cfg_sel_b = 1'b0;
        wait_cyc(300);

        // R9: missing-edge window and recovery on the unused reference B
        b_on = 1'b0;
        wait_cyc(12);
        check(ref_ok[1] == 1'b1, "R9", "still good inside window", int'(ref_ok[1]), 1);
        wait_cyc(48);
        check(ref_ok[1] == 1'b0, "R9", "bad after window", int'(ref_ok[1]), 0);
        b_on = 1'b1;
        wait_cyc(20);
        check(ref_ok[1] == 1'b0, "R9", "bad before enough edges", int'(ref_ok[1]), 0);
        wait_cyc(40);
        check(ref_ok[1] == 1'b1, "R9", "good after edge run", int'(ref_ok[1]), 1);
        wait_cyc(100);

        // R6: switch to a stopped reference stalls, then lands
        b_on = 1'b0;
        wait_cyc(100);
        cfg_sel_b = 1'b1;
        wait_cyc(300);
        check(sel_b_active == 1'b0, "R6", "flag while target stopped", int'(sel_b_active), 0);
        measure(rises, per);
        check(rises == 0, "R6", "output edges while stalled", rises, 0);
        @(negedge sys_clk);
        b_on = 1'b1;
        wait_cyc(300);
        check(sel_b_active == 1'b1, "R6", "flag after target starts", int'(sel_b_active), 1);
        measure(rises, per);
        check(per == PER_B, "R6", "period after target starts", per, PER_B);
        @(negedge sys_clk);
        cfg_sel_b = 1'b0;
        wait_cyc(300);

        // R7: bypass switches at once, even to a stopped reference
        cfg_deglitch_off = 1'b1;
        b_on = 1'b0;
        wait_cyc(100);
        cfg_sel_b = 1'b1;
        wait_cyc(4);
        check(sel_b_active == 1'b1, "R7", "bypass flag to stopped B", int'(sel_b_active), 1);
        measure(rises, per);
        check(rises == 0, "R7", "bypass output follows stopped B", rises, 0);
        @(negedge sys_clk);
        cfg_sel_b = 1'b0;
        wait_cyc(4);
        check(sel_b_active == 1'b0, "R7", "bypass flag back to A", int'(sel_b_active), 0);
        measure(rises, per);
        check(per == PER_A, "R7", "bypass period A", per, PER_A);
        @(negedge sys_clk);
        b_on = 1'b1;
        wait_cyc(100);
        cfg_deglitch_off = 1'b0;
        wait_cyc(300);
        measure(rises, per);
        check(per == PER_A, "R7", "period after bypass cleared", per, PER_A);

        check(runts == 0, "R8", "short output phases", runts, 0);
        finish_run();
    end

endmodule